// File: doc/BRIEF.md
# Time-of-Flight Pixel Acquisition Sequencer

This block runs one complete correlation acquisition on a time-of-flight pixel array. When a start command arrives while it is idle, it latches its configuration. It then steps the sensor through a fixed sequence for every phase step:

- background calibration;
- charge reset, with calibration still held;
- an integration window, during which the modulation and reference clocks are enabled;
- a readout, in which a SELECT strobe presents the array eight pixels at a time.

The phase-step loop sits inside an averaging loop. That loop replays the whole correlation triangle a programmable number of times before a single done pulse is issued.

The sequencer reports where it stands through three outputs: the current phase index, the pixel-group index and the pass number. Downstream capture logic uses them to place each digitised group. Every duration is a cycle count of the block clock, so a length can range from microseconds to milliseconds. The SELECT half-period is a build parameter. Its default of 6 cycles gives roughly a 10 MHz strobe from a 125 MHz clock.

Top module: `tof_seq`

## Requirements
- R1: A start pulse seen while idle latches all configuration inputs and begins with calibration alone (`sensCalib` high, `sensReset` low) for `calLen` cycles.
- R2: Calibration is followed by `rstLen` cycles with both `sensReset` and `sensCalib` high. The two lines then fall in the same cycle. `sensReset` is never high without `sensCalib`.
- R3: `clkEnable` is high for exactly `intLen` cycles, starting in the cycle after reset is released. It is never high together with calibration or SELECT. A configured length of zero on `calLen`, `rstLen` or `intLen` acts as one cycle.
- R4: Readout begins with a rising edge of `selStrobe` in the cycle after integration ends. The number of groups is `pixCount` divided by eight, rounded down, with a minimum of one. Each group holds `selStrobe` high for SEL_HALF cycles and then low for SEL_HALF cycles. `groupIdx` runs 0, 1, 2, … and changes only on a SELECT rising edge, or back to 0.
- R5: After each readout `phaseIdx` advances by one and the cycle restarts at calibration. There are `phaseCount` phase steps, numbered 0 to `phaseCount`-1, and zero acts as one.
- R6: After the last phase step `passIdx` advances and `phaseIdx` returns to 0. There are `avgCount` passes, up to 256, and zero acts as one. After completion `passIdx` holds the last pass number until the next start.
- R7: After the final readout of the final pass, `done` is high for exactly one cycle. In that cycle all sensor lines are low and `phaseIdx` is 0.
- R8: A start pulse while a run is active is ignored, and changes to the configuration inputs during a run have no effect on that run.
- R9: While reset is held, all outputs are low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle start command |
| calLen | input | CNT_W | Calibration duration in cycles |
| rstLen | input | CNT_W | Reset duration in cycles |
| intLen | input | CNT_W | Integration duration in cycles |
| pixCount | input | PIX_W | Number of pixels in the array |
| phaseCount | input | PH_W | Phase steps per triangle |
| avgCount | input | AVG_W | Number of averaging passes |
| sensCalib | output | 1 | Background calibration line |
| sensReset | output | 1 | Integration reset line |
| clkEnable | output | 1 | Enables modulation and reference clocks |
| selStrobe | output | 1 | Readout SELECT strobe |
| phaseIdx | output | PH_W | Current phase step |
| groupIdx | output | PIX_W-3 | Current eight-pixel group |
| passIdx | output | AVG_W | Current averaging pass |
| done | output | 1 | One-cycle completion pulse |

## Verification
Several ordering rules are checked on every cycle:

- reset only while calibration is held;
- the clock enable isolated from both calibration and SELECT;
- integration starting right after reset release;
- the first SELECT edge directly after integration;
- group, phase and pass indices changing only at their legal moments;
- `done` being a quiet single-cycle pulse.

The exact lengths of each segment, the group count derived from `pixCount`, and the loop counts need the bench's scenarios. So do the zero-as-one rule, immunity to a second start and to configuration changes mid-run, and the 256-pass boundary. The bench compares every observed segment and SELECT pulse against an expected stream built from the configuration.

// File: rtl/tof_seq_pkg.sv
package tof_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAL,
    ST_RST,
    ST_INT,
    ST_RD
  } seqState_t;

  // which limit the shared timer compares against
  typedef enum logic [1:0] {
    SEG_CAL,
    SEG_RST,
    SEG_INT,
    SEG_RD
  } seg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic tmrClr;
    logic grpInc;
    logic grpClr;
    logic phInc;
    logic phClr;
    logic psInc;
    logic psClr;
    seg_t seg;
  } seqStb_t;

endpackage

// File: rtl/tof_seq_dp.sv
module tof_seq_dp
  import tof_seq_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int PIX_W    = 15,
  parameter int PH_W     = 6,
  parameter int AVG_W    = 9,
  parameter int SEL_HALF = 6,
  localparam int GRP_W   = PIX_W - 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStb_t          stb,
  input  logic [CNT_W-1:0] calLen,
  input  logic [CNT_W-1:0] rstLen,
  input  logic [CNT_W-1:0] intLen,
  input  logic [PIX_W-1:0] pixCount,
  input  logic [PH_W-1:0]  phaseCount,
  input  logic [AVG_W-1:0] avgCount,
  output logic             tLast,
  output logic             grpLast,
  output logic             phLast,
  output logic             psLast,
  output logic             selHi,
  output logic [PH_W-1:0]  phaseIdx,
  output logic [GRP_W-1:0] groupIdx,
  output logic [AVG_W-1:0] passIdx
);

  localparam logic [CNT_W-1:0] SEL_HALF_C = CNT_W'(SEL_HALF);
  localparam logic [CNT_W-1:0] RD_LIM     = CNT_W'(2 * SEL_HALF - 1);

  logic [CNT_W-1:0] calLim, rstLim, intLim, tmr, curLim;
  logic [GRP_W-1:0] grpLim;
  logic [PH_W-1:0]  phLim;
  logic [AVG_W-1:0] psLim;
  logic [GRP_W-1:0] grpRaw;

  assign grpRaw = pixCount[PIX_W-1:3];

  // configuration snapshot, stored as last index (zero acts as one)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calLim <= '0;
      rstLim <= '0;
      intLim <= '0;
      grpLim <= '0;
      phLim  <= '0;
      psLim  <= '0;
    end else if (stb.load) begin
      calLim <= (calLen == '0) ? '0 : calLen - 1'b1;
      rstLim <= (rstLen == '0) ? '0 : rstLen - 1'b1;
      intLim <= (intLen == '0) ? '0 : intLen - 1'b1;
      grpLim <= (grpRaw == '0) ? '0 : grpRaw - 1'b1;
      phLim  <= (phaseCount == '0) ? '0 : phaseCount - 1'b1;
      psLim  <= (avgCount == '0) ? '0 : avgCount - 1'b1;
    end
  end

  always_comb begin
    unique case (stb.seg)
      SEG_CAL: curLim = calLim;
      SEG_RST: curLim = rstLim;
      SEG_INT: curLim = intLim;
      default: curLim = RD_LIM;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           tmr <= '0;
    else if (stb.tmrClr) tmr <= '0;
    else                 tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           groupIdx <= '0;
    else if (stb.grpClr) groupIdx <= '0;
    else if (stb.grpInc) groupIdx <= groupIdx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          phaseIdx <= '0;
    else if (stb.phClr) phaseIdx <= '0;
    else if (stb.phInc) phaseIdx <= phaseIdx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          passIdx <= '0;
    else if (stb.psClr) passIdx <= '0;
    else if (stb.psInc) passIdx <= passIdx + 1'b1;
  end

  assign tLast   = (tmr == curLim);
  assign selHi   = (tmr < SEL_HALF_C);
  assign grpLast = (groupIdx == grpLim);
  assign phLast  = (phaseIdx == phLim);
  assign psLast  = (passIdx == psLim);

endmodule

// File: rtl/tof_seq_ctrl.sv
module tof_seq_ctrl
  import tof_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    tLast,
  input  logic    grpLast,
  input  logic    phLast,
  input  logic    psLast,
  input  logic    selHi,
  output seqStb_t stb,
  output logic    sensCalib,
  output logic    sensReset,
  output logic    clkEnable,
  output logic    selStrobe,
  output logic    done
);

  seqState_t state, nxt;
  logic      doneNxt;

  always_comb begin
    stb     = '0;
    nxt     = state;
    doneNxt = 1'b0;
    unique case (state)
      ST_IDLE: begin
        stb.seg = SEG_CAL;
        if (start) begin
          stb.load   = 1'b1;
          stb.tmrClr = 1'b1;
          stb.grpClr = 1'b1;
          stb.phClr  = 1'b1;
          stb.psClr  = 1'b1;
          nxt        = ST_CAL;
        end
      end
      ST_CAL: begin
        stb.seg = SEG_CAL;
        if (tLast) begin
          stb.tmrClr = 1'b1;
          nxt        = ST_RST;
        end
      end
      ST_RST: begin
        stb.seg = SEG_RST;
        if (tLast) begin
          stb.tmrClr = 1'b1;
          nxt        = ST_INT;
        end
      end
      ST_INT: begin
        stb.seg = SEG_INT;
        if (tLast) begin
          stb.tmrClr = 1'b1;
          stb.grpClr = 1'b1;
          nxt        = ST_RD;
        end
      end
      default: begin
        stb.seg = SEG_RD;
        if (tLast) begin
          stb.tmrClr = 1'b1;
          if (!grpLast) begin
            stb.grpInc = 1'b1;
          end else begin
            stb.grpClr = 1'b1;
            nxt        = ST_CAL;
            if (!phLast) begin
              stb.phInc = 1'b1;
            end else begin
              stb.phClr = 1'b1;
              if (!psLast) begin
                stb.psInc = 1'b1;
              end else begin
                nxt     = ST_IDLE;
                doneNxt = 1'b1;
              end
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= doneNxt;
    end
  end

  assign sensCalib = (state == ST_CAL) || (state == ST_RST);
  assign sensReset = (state == ST_RST);
  assign clkEnable = (state == ST_INT);
  assign selStrobe = (state == ST_RD) && selHi;

endmodule

// File: rtl/tof_seq.sv
module tof_seq
  import tof_seq_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int PIX_W    = 15,
  parameter int PH_W     = 6,
  parameter int AVG_W    = 9,
  parameter int SEL_HALF = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] calLen,
  input  logic [CNT_W-1:0] rstLen,
  input  logic [CNT_W-1:0] intLen,
  input  logic [PIX_W-1:0] pixCount,
  input  logic [PH_W-1:0]  phaseCount,
  input  logic [AVG_W-1:0] avgCount,
  output logic             sensCalib,
  output logic             sensReset,
  output logic             clkEnable,
  output logic             selStrobe,
  output logic [PH_W-1:0]  phaseIdx,
  output logic [PIX_W-4:0] groupIdx,
  output logic [AVG_W-1:0] passIdx,
  output logic             done
);

  seqStb_t stb;
  logic    tLast, grpLast, phLast, psLast, selHi;

  tof_seq_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .tLast    (tLast),
    .grpLast  (grpLast),
    .phLast   (phLast),
    .psLast   (psLast),
    .selHi    (selHi),
    .stb      (stb),
    .sensCalib(sensCalib),
    .sensReset(sensReset),
    .clkEnable(clkEnable),
    .selStrobe(selStrobe),
    .done     (done)
  );

  tof_seq_dp #(
    .CNT_W   (CNT_W),
    .PIX_W   (PIX_W),
    .PH_W    (PH_W),
    .AVG_W   (AVG_W),
    .SEL_HALF(SEL_HALF)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .calLen    (calLen),
    .rstLen    (rstLen),
    .intLen    (intLen),
    .pixCount  (pixCount),
    .phaseCount(phaseCount),
    .avgCount  (avgCount),
    .tLast     (tLast),
    .grpLast   (grpLast),
    .phLast    (phLast),
    .psLast    (psLast),
    .selHi     (selHi),
    .phaseIdx  (phaseIdx),
    .groupIdx  (groupIdx),
    .passIdx   (passIdx)
  );

endmodule

// File: rtl/tof_seq_chk.sv
module tof_seq_chk #(
  parameter int PIX_W = 15,
  parameter int PH_W  = 6,
  parameter int AVG_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             sensCalib,
  input logic             sensReset,
  input logic             clkEnable,
  input logic             selStrobe,
  input logic [PH_W-1:0]  phaseIdx,
  input logic [PIX_W-4:0] groupIdx,
  input logic [AVG_W-1:0] passIdx,
  input logic             done
);

  AST_RST_UNDER_CAL: assert property (@(posedge clk) disable iff (!rstN)
    sensReset |-> sensCalib); // R2

  AST_CLK_ISOLATED: assert property (@(posedge clk) disable iff (!rstN)
    clkEnable |-> (!sensCalib && !selStrobe)); // R3

  AST_INT_AFTER_RST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkEnable) |-> $past(sensReset)); // R3

  AST_SEL_ENDS_INT: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(selStrobe) && groupIdx == '0) |-> $past(clkEnable)); // R4

  AST_GROUP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (groupIdx != $past(groupIdx)) |-> ($rose(selStrobe) || groupIdx == '0)); // R4

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (phaseIdx != $past(phaseIdx)) |-> (sensCalib || done)); // R5

  AST_PASS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (passIdx != $past(passIdx)) |-> (sensCalib && phaseIdx == '0)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!sensCalib && !sensReset && !clkEnable && !selStrobe && phaseIdx == '0)); // R7

endmodule

bind tof_seq tof_seq_chk #(
  .PIX_W(PIX_W),
  .PH_W (PH_W),
  .AVG_W(AVG_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .sensCalib(sensCalib),
  .sensReset(sensReset),
  .clkEnable(clkEnable),
  .selStrobe(selStrobe),
  .phaseIdx (phaseIdx),
  .groupIdx (groupIdx),
  .passIdx  (passIdx),
  .done     (done)
);

// File: tb/tof_seq_tb_top.sv
module tof_seq_tb_top;

  localparam int CNT_W    = 24;
  localparam int PIX_W    = 15;
  localparam int PH_W     = 6;
  localparam int AVG_W    = 9;
  localparam int SEL_HALF = 6;

  localparam int K_CAL  = 0;
  localparam int K_RST  = 1;
  localparam int K_INT  = 2;
  localparam int K_SEL  = 3;
  localparam int K_DONE = 4;

  typedef struct packed {
    int kind;
    int ph;
    int grp;
    int ps;
    int len;
  } item_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] calLen = '0, rstLen = '0, intLen = '0;
  logic [PIX_W-1:0] pixCount = '0;
  logic [PH_W-1:0]  phaseCount = '0;
  logic [AVG_W-1:0] avgCount = '0;
  logic             sensCalib, sensReset, clkEnable, selStrobe, done;
  logic [PH_W-1:0]  phaseIdx;
  logic [PIX_W-4:0] groupIdx;
  logic [AVG_W-1:0] passIdx;

  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;
  item_t expQ[$];

  always #4 clk = ~clk;

  tof_seq #(
    .CNT_W(CNT_W), .PIX_W(PIX_W), .PH_W(PH_W), .AVG_W(AVG_W), .SEL_HALF(SEL_HALF)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start),
    .calLen(calLen), .rstLen(rstLen), .intLen(intLen),
    .pixCount(pixCount), .phaseCount(phaseCount), .avgCount(avgCount),
    .sensCalib(sensCalib), .sensReset(sensReset), .clkEnable(clkEnable),
    .selStrobe(selStrobe), .phaseIdx(phaseIdx), .groupIdx(groupIdx),
    .passIdx(passIdx), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      finish();
    end
  end

  // monitor: measures segments and compares with the expected stream
  int  calCnt = 0, rstCnt = 0, intCnt = 0, selCnt = 0;
  bit  pRst = 0, pInt = 0, pSel = 0;

  task automatic observe(input item_t o);
    item_t e;
    string req;
    if (expQ.size() == 0) begin
      check(1'b0, "R8", "unexpected item kind", o.kind, -1);
      return;
    end
    e = expQ.pop_front();
    case (e.kind)
      K_CAL:   req = "R1";
      K_RST:   req = "R2";
      K_INT:   req = "R3";
      K_SEL:   req = "R4";
      default: req = "R7";
    endcase
    if (o.kind != e.kind) check(1'b0, req, "item kind", o.kind, e.kind);
    else if (o.ph != e.ph) check(1'b0, "R5", "phase index", o.ph, e.ph);
    else if (o.ps != e.ps) check(1'b0, "R6", "pass index", o.ps, e.ps);
    else if (o.grp != e.grp) check(1'b0, "R4", "group index", o.grp, e.grp);
    else check(o.len == e.len, req, "segment length", o.len, e.len);
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (sensCalib && !sensReset) calCnt++;
      if (sensReset) rstCnt++;
      if (clkEnable) intCnt++;
      if (selStrobe) selCnt++;
      if (sensReset && !pRst) begin
        observe('{K_CAL, 0, 0, 0, calCnt});
        calCnt = 0;
      end
      if (!sensReset && pRst) begin
        check(!sensCalib, "R2", "calib released with reset", int'(sensCalib), 0);
        observe('{K_RST, 0, 0, 0, rstCnt});
        rstCnt = 0;
      end
      if (!clkEnable && pInt) begin
        observe('{K_INT, 0, 0, 0, intCnt});
        intCnt = 0;
      end
      if (!selStrobe && pSel) begin
        observe('{K_SEL, int'(phaseIdx), int'(groupIdx), int'(passIdx), selCnt});
        selCnt = 0;
      end
      if (done) observe('{K_DONE, int'(phaseIdx), 0, int'(passIdx), 0});
      pRst = sensReset;
      pInt = clkEnable;
      pSel = selStrobe;
    end
  end

  // driver: builds the expected stream, then runs the sequencer
  task automatic runCase(input int cl, input int rl, input int il, input int px,
                         input int ph, input int av, input bit poke, input string tag);
    int cE = (cl == 0) ? 1 : cl;
    int rE = (rl == 0) ? 1 : rl;
    int iE = (il == 0) ? 1 : il;
    int gE = (px / 8 == 0) ? 1 : px / 8;
    int pE = (ph == 0) ? 1 : ph;
    int aE = (av == 0) ? 1 : av;
    for (int p = 0; p < aE; p++) begin
      for (int s = 0; s < pE; s++) begin
        expQ.push_back('{K_CAL, 0, 0, 0, cE});
        expQ.push_back('{K_RST, 0, 0, 0, rE});
        expQ.push_back('{K_INT, 0, 0, 0, iE});
        for (int g = 0; g < gE; g++) expQ.push_back('{K_SEL, s, g, p, SEL_HALF});
      end
    end
    expQ.push_back('{K_DONE, 0, 0, aE - 1, 0});
    @(negedge clk);
    calLen = CNT_W'(cl); rstLen = CNT_W'(rl); intLen = CNT_W'(il);
    pixCount = PIX_W'(px); phaseCount = PH_W'(ph); avgCount = AVG_W'(av);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(sensCalib && !sensReset, "R1", {tag, " calibration first"}, int'(sensCalib), 1);
    if (poke) begin
      repeat (7) @(negedge clk);
      start = 1'b1;
      calLen = 40; rstLen = 40; intLen = 40; pixCount = 200; phaseCount = 9; avgCount = 7;
      @(negedge clk);
      start = 1'b0;
    end
    @(posedge done);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R8", {tag, " leftover expected items"}, expQ.size(), 0);
    expQ.delete();
    check(int'(passIdx) == aE - 1, "R6", {tag, " pass index holds"}, int'(passIdx), aE - 1);
    check(!sensCalib && !sensReset && !clkEnable && !selStrobe && !done, "R7",
          {tag, " idle after done"}, int'({sensCalib, sensReset, clkEnable, selStrobe, done}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({sensCalib, sensReset, clkEnable, selStrobe, done} == '0, "R9", "control lines in reset",
          int'({sensCalib, sensReset, clkEnable, selStrobe, done}), 0);
    check(phaseIdx == '0 && groupIdx == '0 && passIdx == '0, "R9", "indices in reset",
          int'(phaseIdx) + int'(groupIdx) + int'(passIdx), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1 R2 R3 R4 R5 R6 R7: nominal loop
    runCase(3, 2, 5, 32, 3, 2, 1'b0, "nominal");
    // R3 R4 R5 R6: zero lengths and sub-group pixel count act as one
    runCase(0, 0, 0, 5, 0, 0, 1'b0, "zeros");
    // R8: second start and config changes mid-run
    runCase(2, 4, 3, 24, 2, 3, 1'b1, "busy");
    // R4 R5: full sixteen phase steps, sixteen groups
    runCase(10, 6, 20, 128, 16, 1, 1'b0, "sixteen");
    // R6: 256 averaging passes
    runCase(1, 1, 1, 8, 1, 256, 1'b0, "avg256");
    finish();
  end

endmodule